// File: doc/BRIEF.md
# Next-Fit Translation Entry Allocator with Deferred Flush

This block tracks which entries of a translation table are in use, one bit per entry. A requester asks for an entry and gets back either the index of a free entry or a full indication. A separate port returns entries to the pool. Allocation is next-fit. Each search starts one position past the entry handed out most recently, walks upward, and steps back to entry 0 only after passing the last entry.

Freed entries may still sit in a downstream translation cache. Freeing therefore never invalidates anything. Instead, the block raises a whole-cache flush request each time the search position rolls over from the last entry to entry 0. A freed entry can only be handed out again after such a rollover, so that point is the only place a flush is needed. Until the flush is acknowledged, no allocation completes.

The search looks at a window of eight consecutive entries per clock. The window is cut short at the end of the table so that the rollover is always seen.

Top module: `nextfit_alloc`

## Requirements
- R1: After reset, `alloc_done`, `flush_req` and `free_err` are low and every entry is free.
- R2: A successful allocation returns the lowest-numbered free entry at or above the search position. The search position is entry 0 after reset, and one past the last granted entry after each grant. If no free entry exists from there to the top, the result is the lowest-numbered free entry from entry 0 upward.
- R3: A granted entry is marked used and is not granted again until it has been freed.
- R4: Each rollover of the search position from the last entry to entry 0 raises `flush_req` exactly once. A rollover happens when the last entry is granted, or when a search passes the last entry without finding a free one.
- R5: `flush_req` stays high until a cycle in which `flush_ack` is high. While it is high, no allocation completes, except the grant of the last entry in the cycle the flush is raised.
- R6: Freeing an entry never raises `flush_req`.
- R7: When every entry is used, a request completes with `alloc_done` and `alloc_full` both high, and the search position is left unchanged.
- R8: Freeing an entry that is already free sets `free_err`, which stays set until reset, and leaves the entry states unchanged.
- R9: `alloc_done` is a one-cycle pulse. The requester holds `alloc_req` high until it sees the pulse. A request still high in the pulse cycle is not served a second time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Allocation request, held until `alloc_done` |
| alloc_done | output | 1 | One-cycle completion pulse |
| alloc_full | output | 1 | With `alloc_done`: no free entry existed |
| alloc_idx | output | IDX_W | Granted entry index, valid with `alloc_done` when not full |
| free_req | input | 1 | Return one entry to the pool |
| free_idx | input | IDX_W | Entry being returned |
| flush_req | output | 1 | Whole-cache flush request |
| flush_ack | input | 1 | Flush complete |
| free_err | output | 1 | Sticky flag: an already-free entry was freed |

## Verification
The assertions rely on three assumptions about the inputs. The requester keeps `alloc_req` steady until the done pulse. `flush_ack` arrives only while `flush_req` is high. `free_idx` is always below the table size. The stimulus meets all three by design. Each allocation is a task that raises the request and lowers it in the cycle the pulse is seen. Acknowledges are issued only after a high `flush_req` is observed, with a random delay. Freed indices are drawn within the table. Double frees are issued on purpose.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_FLUSH = 2'd2
  } nfa_state_e;
endpackage

// File: rtl/nfa_bitmap.sv
module nfa_bitmap #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     used,
  output logic             all_used,
  output logic             dbl_free_err
);
  localparam int SPAN = 1 << IDX_W;

  logic [N-1:0]    used_q, used_d;
  logic [SPAN-1:0] used_pad;
  logic            clr_hit, clr_ok, err_q, err_d, map_en;

  assign used_pad = SPAN'(used_q);
  assign clr_hit  = used_pad[clr_idx];
  assign clr_ok   = clr_en && clr_hit;
  assign map_en   = set_en || clr_ok;

  always_comb begin
    used_d = used_q;
    if (set_en) used_d[set_idx] = 1'b1;
    if (clr_ok) used_d[clr_idx] = 1'b0;
    err_d = err_q | (clr_en & ~clr_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (map_en) used_q <= used_d;
      err_q <= err_d;
    end
  end

  assign used         = used_q;
  assign all_used     = &used_q;
  assign dbl_free_err = err_q;

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R3
  grant_free_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !used_pad[set_idx]);
endmodule

// File: rtl/nfa_window.sv
module nfa_window #(
  parameter int N     = 64,
  parameter int LANES = 8,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     used,
  input  logic [IDX_W-1:0] cursor,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             at_end,
  output logic [IDX_W-1:0] next_cursor
);
  localparam int SPAN = 1 << IDX_W;
  localparam int PW   = IDX_W + 1;

  logic [SPAN-1:0]  used_pad;
  logic [LANES-1:0] lane_free;
  logic [PW-1:0]    lane_pos [LANES];
  logic [PW-1:0]    end_pos;

  assign used_pad = SPAN'(used);

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_pos[k]  = {1'b0, cursor} + PW'(k);
      assign lane_free[k] = (lane_pos[k] < PW'(N)) &&
                            !used_pad[lane_pos[k][IDX_W-1:0]];
    end
  endgenerate

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (lane_free[k]) begin
        hit     = 1'b1;
        hit_idx = lane_pos[k][IDX_W-1:0];
      end
    end
  end

  assign end_pos     = {1'b0, cursor} + PW'(LANES);
  assign at_end      = end_pos >= PW'(N);
  assign next_cursor = end_pos[IDX_W-1:0];
endmodule

// File: rtl/nfa_ctrl.sv
module nfa_ctrl
  import nfa_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             all_used,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             at_end,
  input  logic [IDX_W-1:0] next_cursor,
  input  logic             flush_ack,
  output logic [IDX_W-1:0] cursor,
  output logic             set_en,
  output logic [IDX_W-1:0] set_idx,
  output logic             alloc_done,
  output logic             alloc_full,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             flush_req
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  nfa_state_e       state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d, ptr_q, ptr_d, idx_q, idx_d;
  logic             resume_q, resume_d, done_q, done_d, full_q, full_d;

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    ptr_d    = ptr_q;
    idx_d    = idx_q;
    resume_d = resume_q;
    done_d   = 1'b0;
    full_d   = 1'b0;
    set_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (alloc_req && !done_q) begin
          if (all_used) begin
            done_d = 1'b1;
            full_d = 1'b1;
          end else begin
            state_d = ST_SCAN;
            cur_d   = ptr_q;
          end
        end
      end
      ST_SCAN: begin
        if (hit) begin
          set_en = 1'b1;
          done_d = 1'b1;
          idx_d  = hit_idx;
          if (hit_idx == LAST) begin
            ptr_d    = '0;
            state_d  = ST_FLUSH;
            resume_d = 1'b0;
          end else begin
            ptr_d   = hit_idx + 1'b1;
            state_d = ST_IDLE;
          end
        end else if (at_end) begin
          state_d  = ST_FLUSH;
          resume_d = 1'b1;
          cur_d    = '0;
        end else begin
          cur_d = next_cursor;
        end
      end
      ST_FLUSH: begin
        if (flush_ack) state_d = resume_q ? ST_SCAN : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      ptr_q    <= '0;
      idx_q    <= '0;
      resume_q <= 1'b0;
      done_q   <= 1'b0;
      full_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      ptr_q    <= ptr_d;
      resume_q <= resume_d;
      done_q   <= done_d;
      full_q   <= full_d;
      if (done_d) idx_q <= idx_d;
    end
  end

  assign cursor     = cur_q;
  assign set_idx    = hit_idx;
  assign alloc_done = done_q;
  assign alloc_full = full_q;
  assign alloc_idx  = idx_q;
  assign flush_req  = (state_q == ST_FLUSH);

  // R5
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req);

  // R5
  flush_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && $past(flush_req) |-> !alloc_done);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |=> !alloc_done);

  // R6
  flush_from_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> $past(state_q == ST_SCAN));

  // R7
  full_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_full |-> $stable(ptr_q));
endmodule

// File: rtl/nextfit_alloc.sv
module nextfit_alloc #(
  parameter int N     = 64,
  parameter int LANES = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  output logic             alloc_done,
  output logic             alloc_full,
  output logic [IDX_W-1:0] alloc_idx,
  input  logic             free_req,
  input  logic [IDX_W-1:0] free_idx,
  output logic             flush_req,
  input  logic             flush_ack,
  output logic             free_err
);
  logic [N-1:0]     used;
  logic             all_used, hit, at_end, set_en;
  logic [IDX_W-1:0] hit_idx, next_cursor, cursor, set_idx;

  nfa_bitmap #(.N(N), .IDX_W(IDX_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_idx(set_idx),
    .clr_en(free_req), .clr_idx(free_idx),
    .used(used), .all_used(all_used), .dbl_free_err(free_err)
  );

  nfa_window #(.N(N), .LANES(LANES), .IDX_W(IDX_W)) u_win (
    .used(used), .cursor(cursor),
    .hit(hit), .hit_idx(hit_idx),
    .at_end(at_end), .next_cursor(next_cursor)
  );

  nfa_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .all_used(all_used),
    .hit(hit), .hit_idx(hit_idx), .at_end(at_end), .next_cursor(next_cursor),
    .flush_ack(flush_ack), .cursor(cursor),
    .set_en(set_en), .set_idx(set_idx),
    .alloc_done(alloc_done), .alloc_full(alloc_full), .alloc_idx(alloc_idx),
    .flush_req(flush_req)
  );
endmodule

// File: tb/nextfit_alloc_test.sv
module nextfit_alloc_test;
  localparam int N     = 64;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0, free_req = 1'b0, flush_ack = 1'b0;
  logic [IDX_W-1:0] free_idx = '0;
  logic alloc_done, alloc_full, flush_req, free_err;
  logic [IDX_W-1:0] alloc_idx;

  int tests = 0, fails = 0;
  bit done_flag = 0;
  bit mdl [N];
  int ptr = 0;
  bit pend = 0;
  bit err_exp = 0;

  always #2 clk = ~clk;

  nextfit_alloc #(.N(N), .LANES(8)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
    .alloc_done(alloc_done), .alloc_full(alloc_full), .alloc_idx(alloc_idx),
    .free_req(free_req), .free_idx(free_idx),
    .flush_req(flush_req), .flush_ack(flush_ack), .free_err(free_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find_from(input int start);
    for (int i = start; i < N; i++) if (!mdl[i]) return i;
    return -1;
  endfunction

  function automatic bit model_full();
    for (int i = 0; i < N; i++) if (!mdl[i]) return 0;
    return 1;
  endfunction

  task automatic do_alloc();
    int exp_idx, exp_fl, flushes, cyc, act_idx;
    bit exp_full, got, act_full;
    exp_fl = pend ? 1 : 0;
    exp_full = model_full();
    exp_idx = -1;
    if (!exp_full) begin
      exp_idx = find_from(ptr);
      if (exp_idx < 0) begin
        exp_fl++;
        exp_idx = find_from(0);
      end
    end
    @(negedge clk);
    alloc_req = 1'b1;
    flushes = 0; got = 0; cyc = 0; act_full = 0; act_idx = 0;
    while (!got && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (alloc_done) begin
        got = 1;
        act_full = alloc_full;
        act_idx = int'(alloc_idx);
        alloc_req = 1'b0;
      end else if (flush_req) begin
        flushes++;
        repeat ($urandom_range(0, 3)) begin
          @(negedge clk);
          // R5: no completion while flush outstanding
          chk(!alloc_done && flush_req, "R5", int'(alloc_done), 0);
        end
        flush_ack = 1'b1;
        @(negedge clk);
        flush_ack = 1'b0;
      end
    end
    alloc_req = 1'b0;
    chk(got, "R9", int'(got), 1);
    chk(flushes == exp_fl, "R4", flushes, exp_fl);
    chk(act_full == exp_full, "R7", int'(act_full), int'(exp_full));
    if (!exp_full) begin
      chk(act_idx == exp_idx, "R2", act_idx, exp_idx);
      mdl[exp_idx] = 1;
      if (exp_idx == N - 1) begin ptr = 0; pend = 1; end
      else begin ptr = exp_idx + 1; pend = 0; end
      // R4: granting the last entry raises the flush at once
      chk(flush_req == pend, "R4", int'(flush_req), int'(pend));
    end else begin
      pend = 0;
    end
    @(negedge clk);
    // R9: single pulse
    chk(!alloc_done, "R9", int'(alloc_done), 0);
  endtask

  task automatic do_free(input int idx);
    @(negedge clk);
    free_req = 1'b1;
    free_idx = IDX_W'(idx);
    @(negedge clk);
    free_req = 1'b0;
    if (mdl[idx]) mdl[idx] = 0; else err_exp = 1;
    // R8
    chk(free_err == err_exp, "R8", int'(free_err), int'(err_exp));
    // R6
    chk(flush_req == pend, "R6", int'(flush_req), int'(pend));
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!alloc_done && !flush_req && !free_err, "R1",
        int'({alloc_done, flush_req, free_err}), 0);

    for (int i = 0; i < N; i++) do_alloc();   // R2 R3: 0..N-1 in order
    do_alloc();                               // R7 after pending flush
    do_free(10); do_free(5); do_free(40);
    do_alloc(); do_alloc(); do_alloc();       // R2: 5, 10, 40
    do_alloc();                               // R7: full
    do_free(3); do_free(50);
    do_alloc();                               // R7 ptr kept: 50
    do_free(60);
    do_alloc();                               // 60
    do_alloc();                               // R4: wrap mid-search, then 3
    do_free(7); do_free(7);                   // R8 double free
    do_alloc();                               // R8 map unchanged: 7

    for (int n = 0; n < 500; n++) begin
      if ($urandom_range(0, 99) < 55) do_alloc();
      else do_free($urandom_range(0, N - 1));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule